// File: doc/BRIEF.md
# SAR Converter Control Register Block

This block is the register front end of a successive-approximation analog-to-digital converter. A simple 32-bit register bus (address, write strobe, read strobe, write data, combinational read data) reaches a small set of word-aligned registers. These registers select the input, configure the result policy and launch work on a separate conversion engine. The engine is reached through a start pulse, a channel code, a calibration pulse, a done pulse, a result word and a calibration-fail bit.

Writing a channel code to the first channel-control register launches one conversion on that input. The reserved code 0x1F instead parks the block and abandons any conversion still in flight. Finished results land in the first result register and raise a completion flag, which drives the interrupt when its enable bit is set. A continuous bit in general control makes each finish launch the next conversion on the same input. Writing 1 to the calibration bit of general control runs a calibration pass. The pass/fail outcome is latched in the general status register.

The sequencing is a three-state machine. STOPPED waits for work. CONVERT waits for the engine during a conversion. CALIBRATE waits for the engine during calibration. The transitions are as follows.
- LAUNCH goes from STOPPED to CONVERT on a channel write with a code other than 0x1F.
- RELAUNCH stays in CONVERT on a new channel write, or on a finish with continuous mode on.
- PARK goes from CONVERT to STOPPED on a 0x1F write, or on a finish with continuous mode off.
- CAL_GO goes from STOPPED or CONVERT to CALIBRATE on a write of 1 to the calibration bit.
- CAL_END goes from CALIBRATE to STOPPED on the engine's done pulse.

Top module: `sar_ctl_regs`

## Requirements
- R1: After reset, channel control 0 (offset 0x00) reads 0x0000001F, and every other register reads 0. The interrupt is low and the engine receives no start.
- R2: A write to offset 0x00 stores the channel code from bits [4:0] and the interrupt enable from bit 7. If the code is not 0x1F and no calibration is running, the block drives exactly one start pulse in the following cycle, with the channel output equal to the code.
- R3: When the engine reports done during a conversion, the result is zero-extended into result 0 (offset 0x0C) and status bit 0 (offset 0x08) is set.
- R4: The interrupt output equals status bit 0 AND the interrupt enable bit 7 of offset 0x00.
- R5: A read of offset 0x0C clears status bit 0, unless a new completion arrives in the same cycle.
- R6: With configuration (offset 0x14) bit 16 at 0, a result that arrives while status bit 0 is still set is discarded, and result 0 keeps the older value.
- R7: With configuration bit 16 at 1, a result that arrives while status bit 0 is set replaces the unread one.
- R8: Writing code 0x1F to offset 0x00 launches nothing. It abandons a conversion in flight, so the engine's later done pulse neither sets status bit 0 nor changes result 0.
- R9: With general control (offset 0x18) bit 6 at 1, each conversion finish launches a new conversion on the stored channel. With bit 6 at 0, each channel write produces exactly one conversion.
- R10: Writing 1 to general control bit 7 drives one calibration pulse (never together with a start). Bit 7 reads 1 until the engine's done pulse, then clears itself, and that completion sets status bit 0.
- R11: At the end of calibration, general status (offset 0x1C) bit 1 takes the engine's fail bit. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R12: Addresses that are not a multiple of 4, the hole at 0x2C, and anything above 0x30 read as 0, and writes to them change nothing.
- R13: Channel control 1 (0x04, bits [4:0] and 7), configuration, general control bits [6:0], compare (0x20), offset (0x24), calibration value (0x28) and pin control (0x30) read back what was written. Status and result 0 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for read-to-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_start | output | 1 | One-cycle conversion launch to the engine |
| eng_cal | output | 1 | One-cycle calibration launch to the engine |
| eng_chan | output | 5 | Channel code stored in channel control 0 |
| eng_done | input | 1 | Engine finished the current conversion or calibration |
| eng_result | input | RES_W | Conversion result, valid with eng_done |
| eng_cal_fail | input | 1 | Calibration outcome, valid with eng_done |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with ADDR_W = 8 and RES_W = 12. With 8 address bits, misaligned addresses, the hole at 0x2C and offsets just above 0x30 can all be reached without aliasing. A 12-bit result is wide enough for the bench engine model to pack the channel code and a running sequence number into every result. Each result is therefore distinct, so a discarded result, a replaced result or one swallowed by an abort can be told apart by a single read of result 0. The engine model answers three cycles after each request, which leaves room to land a stop write while a conversion is still in flight.

// File: rtl/sar_regs_pkg.sv
package sar_regs_pkg;

    // Register indices; offsets follow from reg_offset()
    localparam int unsigned NREG = 12;

    typedef enum logic [3:0] {
        RI_CTL0  = 4'd0,
        RI_CTL1  = 4'd1,
        RI_STAT  = 4'd2,
        RI_RES0  = 4'd3,
        RI_RES1  = 4'd4,
        RI_CFG   = 4'd5,
        RI_GCTL  = 4'd6,
        RI_GSTAT = 4'd7,
        RI_CMP   = 4'd8,
        RI_OFS   = 4'd9,
        RI_CALV  = 4'd10,
        RI_PINS  = 4'd11
    } reg_idx_e;

    // Number of plain storage registers starting at RI_CMP
    localparam int unsigned NSTORE = 4;

    // Field positions the behaviour depends on
    localparam int unsigned IE_BIT    = 7;
    localparam int unsigned CONT_BIT  = 6;
    localparam int unsigned CALGO_BIT = 7;
    localparam int unsigned CALF_BIT  = 1;
    localparam int unsigned OVW_BIT   = 16;
    localparam int unsigned CHAN_W    = 5;

    localparam logic [CHAN_W-1:0] CHAN_STOP = 5'h1F;

    typedef enum logic [1:0] {
        ST_STOPPED   = 2'd0,
        ST_CONVERT   = 2'd1,
        ST_CALIBRATE = 2'd2
    } conv_state_e;

    // Byte offset of register idx: word-spaced, the last one skips a word
    function automatic logic [7:0] reg_offset(input int unsigned idx);
        if (idx == 11)
            return 8'h30;
        else
            return 8'(idx * 4);
    endfunction

endpackage

// File: rtl/sar_bus_decode.sv
module sar_bus_decode
    import sar_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [NREG-1:0]   sel,
    output logic [NREG-1:0]   wr_sel,
    output logic [NREG-1:0]   rd_sel
);

    // One comparator per register; unmatched addresses select nothing
    for (genvar gi = 0; gi < NREG; gi++) begin : g_match
        localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(reg_offset(gi));
        assign sel[gi]    = (bus_addr == OFFS);
        assign wr_sel[gi] = sel[gi] & bus_we;
        assign rd_sel[gi] = sel[gi] & bus_re;
    end

endmodule

// File: rtl/sar_conv_fsm.sv
module sar_conv_fsm
    import sar_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_wr,
    input  logic [CHAN_W-1:0] chan_wr_code,
    input  logic [CHAN_W-1:0] chan_cur,
    input  logic              cont_en,
    input  logic              cal_req,
    input  logic              eng_done,
    output logic              eng_start,
    output logic              eng_cal,
    output logic              conv_capture,
    output logic              cal_finish,
    output conv_state_e       state
);

    conv_state_e nxt;
    logic        launch;
    logic        cal_go;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_STOPPED;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt          = state;
        launch       = 1'b0;
        cal_go       = 1'b0;
        conv_capture = 1'b0;
        cal_finish   = 1'b0;
        unique case (state)
            ST_STOPPED: begin
                if (cal_req) begin                              // CAL_GO
                    nxt    = ST_CALIBRATE;
                    cal_go = 1'b1;
                end else if (chan_wr && chan_wr_code != CHAN_STOP) begin  // LAUNCH
                    nxt    = ST_CONVERT;
                    launch = 1'b1;
                end
            end
            ST_CONVERT: begin
                conv_capture = eng_done;
                if (cal_req) begin                              // CAL_GO
                    nxt    = ST_CALIBRATE;
                    cal_go = 1'b1;
                end else if (chan_wr) begin
                    if (chan_wr_code == CHAN_STOP)
                        nxt = ST_STOPPED;                       // PARK
                    else
                        launch = 1'b1;                          // RELAUNCH
                end else if (eng_done) begin
                    if (cont_en && chan_cur != CHAN_STOP)
                        launch = 1'b1;                          // RELAUNCH
                    else
                        nxt = ST_STOPPED;                       // PARK
                end
            end
            ST_CALIBRATE: begin
                if (eng_done) begin                             // CAL_END
                    cal_finish = 1'b1;
                    nxt        = ST_STOPPED;
                end
            end
            default: nxt = ST_STOPPED;
        endcase
    end

    // Registered request pulses to the engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_cal   <= 1'b0;
        end else begin
            eng_start <= launch;
            eng_cal   <= cal_go;
        end
    end

endmodule

// File: rtl/sar_reg_bank.sv
module sar_reg_bank
    import sar_regs_pkg::*;
#(
    parameter int unsigned RES_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   sel,
    input  logic [NREG-1:0]   wr_sel,
    input  logic [NREG-1:0]   rd_sel,
    input  logic [31:0]       wdata,
    input  logic              conv_capture,
    input  logic              cal_finish,
    input  logic [RES_W-1:0]  eng_result,
    input  logic              eng_cal_fail,
    output logic [31:0]       rdata,
    output logic [CHAN_W-1:0] chan_code,
    output logic              chan_ie,
    output logic              cont_en,
    output logic              cal_pending,
    output logic              done_flag,
    output logic              ovw_en
);

    logic [CHAN_W-1:0] ctl1_chan_q;
    logic              ctl1_ie_q;
    logic [31:0]       cfg_q;
    logic [7:0]        gctl_q;
    logic              calf_q;
    logic [RES_W-1:0]  res0_q;
    logic [31:0]       store_q [NSTORE];
    logic [31:0]       rv      [NREG];
    logic              rd_res0;
    logic              take;

    assign rd_res0 = rd_sel[RI_RES0];
    assign ovw_en  = cfg_q[OVW_BIT];
    assign take    = conv_capture && (!done_flag || ovw_en || rd_res0);

    // Channel control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_code   <= CHAN_STOP;
            chan_ie     <= 1'b0;
            ctl1_chan_q <= '0;
            ctl1_ie_q   <= 1'b0;
        end else begin
            if (wr_sel[RI_CTL0]) begin
                chan_code <= wdata[CHAN_W-1:0];
                chan_ie   <= wdata[IE_BIT];
            end
            if (wr_sel[RI_CTL1]) begin
                ctl1_chan_q <= wdata[CHAN_W-1:0];
                ctl1_ie_q   <= wdata[IE_BIT];
            end
        end
    end

    // Configuration, general control and calibration outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            gctl_q <= '0;
            calf_q <= 1'b0;
        end else begin
            if (wr_sel[RI_CFG])
                cfg_q <= wdata;
            if (wr_sel[RI_GCTL])
                gctl_q[CALGO_BIT-1:0] <= wdata[CALGO_BIT-1:0];
            if (cal_finish)
                gctl_q[CALGO_BIT] <= 1'b0;
            else if (wr_sel[RI_GCTL] && wdata[CALGO_BIT])
                gctl_q[CALGO_BIT] <= 1'b1;
            if (cal_finish)
                calf_q <= eng_cal_fail;
            else if (wr_sel[RI_GSTAT] && wdata[CALF_BIT])
                calf_q <= 1'b0;
        end
    end

    assign cont_en     = gctl_q[CONT_BIT];
    assign cal_pending = gctl_q[CALGO_BIT];

    // Result capture and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res0_q    <= '0;
            done_flag <= 1'b0;
        end else begin
            if (take)
                res0_q <= eng_result;
            if (conv_capture || cal_finish)
                done_flag <= 1'b1;
            else if (rd_res0)
                done_flag <= 1'b0;
        end
    end

    // Plain storage registers
    for (genvar gk = 0; gk < NSTORE; gk++) begin : g_store
        localparam int unsigned IDX = int'(RI_CMP) + gk;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store_q[gk] <= '0;
            else if (wr_sel[IDX])
                store_q[gk] <= wdata;
        end
        assign rv[IDX] = store_q[gk];
    end

    // Read views
    assign rv[RI_CTL0]  = {24'd0, chan_ie, 2'd0, chan_code};
    assign rv[RI_CTL1]  = {24'd0, ctl1_ie_q, 2'd0, ctl1_chan_q};
    assign rv[RI_STAT]  = {31'd0, done_flag};
    assign rv[RI_RES0]  = 32'(res0_q);
    assign rv[RI_RES1]  = '0;
    assign rv[RI_CFG]   = cfg_q;
    assign rv[RI_GCTL]  = {24'd0, gctl_q};
    assign rv[RI_GSTAT] = {30'd0, calf_q, 1'b0};

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i])
                rdata = rdata | rv[i];
        end
    end

endmodule

// File: rtl/sar_ctl_regs.sv
module sar_ctl_regs
    import sar_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_start,
    output logic              eng_cal,
    output logic [4:0]        eng_chan,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_result,
    input  logic              eng_cal_fail,
    output logic              irq
);

    logic [NREG-1:0]   sel;
    logic [NREG-1:0]   wr_sel;
    logic [NREG-1:0]   rd_sel;
    logic [CHAN_W-1:0] chan_code;
    logic              chan_ie;
    logic              cont_en;
    logic              cal_pending;
    logic              done_flag;
    logic              ovw_en;
    logic              conv_capture;
    logic              cal_finish;
    conv_state_e       state;

    sar_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .sel      (sel),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel)
    );

    sar_reg_bank #(.RES_W(RES_W)) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .wr_sel       (wr_sel),
        .rd_sel       (rd_sel),
        .wdata        (bus_wdata),
        .conv_capture (conv_capture),
        .cal_finish   (cal_finish),
        .eng_result   (eng_result),
        .eng_cal_fail (eng_cal_fail),
        .rdata        (bus_rdata),
        .chan_code    (chan_code),
        .chan_ie      (chan_ie),
        .cont_en      (cont_en),
        .cal_pending  (cal_pending),
        .done_flag    (done_flag),
        .ovw_en       (ovw_en)
    );

    sar_conv_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_wr      (wr_sel[RI_CTL0]),
        .chan_wr_code (bus_wdata[CHAN_W-1:0]),
        .chan_cur     (chan_code),
        .cont_en      (cont_en),
        .cal_req      (wr_sel[RI_GCTL] & bus_wdata[CALGO_BIT]),
        .eng_done     (eng_done),
        .eng_start    (eng_start),
        .eng_cal      (eng_cal),
        .conv_capture (conv_capture),
        .cal_finish   (cal_finish),
        .state        (state)
    );

    assign eng_chan = chan_code;
    assign irq      = done_flag & chan_ie;

endmodule

// File: rtl/sar_ctl_regs_chk.sv
module sar_ctl_regs_chk
    import sar_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_wdata,
    input logic              eng_start,
    input logic              eng_cal,
    input logic              eng_done,
    input logic              irq,
    input conv_state_e       state,
    input logic              cal_pending,
    input logic              done_flag,
    input logic              ovw_en
);

    logic ctl0_wr;
    logic res0_rd;
    assign ctl0_wr = bus_we && (bus_addr == ADDR_W'(8'h00));
    assign res0_rd = bus_re && (bus_addr == ADDR_W'(8'h0C));

    AST_LAUNCH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_wr && bus_wdata[4:0] != CHAN_STOP && state != ST_CALIBRATE) |=> eng_start); // R2

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_wr && bus_wdata[4:0] == CHAN_STOP) |=> !eng_start); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(eng_done) || $past(ctl0_wr && bus_wdata[IE_BIT]))); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res0_rd && !eng_done) |=> !done_flag); // R5

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_start && eng_cal)); // R10

    AST_CAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_pending) |-> $past(eng_done)); // R10

    AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(eng_done)); // R3

    AST_OVW_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we && bus_addr == ADDR_W'(8'h14)) |-> $stable(ovw_en)); // R13

endmodule

bind sar_ctl_regs sar_ctl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_wdata   (bus_wdata),
    .eng_start   (eng_start),
    .eng_cal     (eng_cal),
    .eng_done    (eng_done),
    .irq         (irq),
    .state       (state),
    .cal_pending (cal_pending),
    .done_flag   (done_flag),
    .ovw_en      (ovw_en)
);

// File: tb/sar_ctl_regs_tb_top.sv
module sar_ctl_regs_tb_top;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned RES_W  = 12;
    localparam int          LAT    = 3;
    localparam int          CALTAG = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              eng_start;
    logic              eng_cal;
    logic [4:0]        eng_chan;
    logic              eng_done = 1'b0;
    logic [RES_W-1:0]  eng_result = '0;
    logic              eng_cal_fail = 1'b0;
    logic              irq;

    int vectors = 0;
    int miscompares = 0;
    int start_cnt = 0;
    int exp_q[$];
    logic [RES_W-1:0] produced[$];
    bit fail_next = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sar_ctl_regs #(.ADDR_W(ADDR_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_cal(eng_cal),
        .eng_chan(eng_chan), .eng_done(eng_done), .eng_result(eng_result),
        .eng_cal_fail(eng_cal_fail), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Engine model and scoreboard monitor: every request is popped and compared
    initial begin
        int dly = 0;
        int seq = 0;
        bit run_cal = 1'b0;
        logic [4:0] run_chan = '0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin
                    eng_done = 1'b1;
                    eng_cal_fail = fail_next;
                    if (!run_cal) begin
                        seq++;
                        eng_result = {run_chan, 7'(seq)};
                        produced.push_back(eng_result);
                    end
                end
            end
            if (rst_n && (eng_start || eng_cal)) begin
                int got;
                start_cnt++;
                run_cal  = eng_cal;
                run_chan = eng_chan;
                dly      = LAT;
                got      = eng_cal ? CALTAG : int'(eng_chan);
                if (exp_q.size() == 0)
                    check("R2 unexpected request", 32'(got), 32'hFFFF_FFFF);
                else
                    check("R2 request order", 32'(got), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int base;
        logic [31:0] keep;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        read_check("R1 ctl0", 8'h00, 32'h1F);
        read_check("R1 status", 8'h08, 32'h0);
        read_check("R1 gctl", 8'h18, 32'h0);
        read_check("R1 cfg", 8'h14, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 no start", 32'(start_cnt), 32'h0);

        // R2 R3 R4 R5 single conversion with interrupt
        exp_q.push_back(5);
        bus_write(8'h00, 32'h85);
        check("R2 start pulse", 32'(eng_start), 32'h1);
        check("R2 channel", 32'(eng_chan), 32'h5);
        idle(8);
        read_check("R3 status set", 8'h08, 32'h1);
        check("R4 irq high", 32'(irq), 32'h1);
        read_check("R2 ctl0 readback", 8'h00, 32'h85);
        read_check("R3 result", 8'h0C, 32'(produced[0]));
        read_check("R5 cleared", 8'h08, 32'h0);
        check("R5 irq low", 32'(irq), 32'h0);
        check("R9 single shot", 32'(start_cnt), 32'h1);

        // R4 gating, R6 discard with overwrite off
        exp_q.push_back(6);
        bus_write(8'h00, 32'h06);
        idle(8);
        read_check("R4 flag set", 8'h08, 32'h1);
        check("R4 irq masked", 32'(irq), 32'h0);
        exp_q.push_back(6);
        bus_write(8'h00, 32'h86);
        check("R4 irq on enable", 32'(irq), 32'h1);
        idle(8);
        read_check("R6 older kept", 8'h0C, 32'(produced[1]));

        // R7 replace with overwrite on
        bus_write(8'h14, 32'h0001_0000);
        read_check("R13 cfg", 8'h14, 32'h0001_0000);
        exp_q.push_back(7);
        bus_write(8'h00, 32'h87);
        idle(8);
        exp_q.push_back(8);
        bus_write(8'h00, 32'h88);
        idle(8);
        read_check("R7 replaced", 8'h0C, 32'(produced[4]));

        // R8 abort in flight and stop code from idle
        keep = 32'(produced[4]);
        base = start_cnt;
        exp_q.push_back(9);
        bus_write(8'h00, 32'h89);
        bus_write(8'h00, 32'h1F);
        idle(8);
        read_check("R8 flag untouched", 8'h08, 32'h0);
        read_check("R8 result untouched", 8'h0C, keep);
        bus_write(8'h00, 32'h1F);
        idle(6);
        check("R8 no launch", 32'(start_cnt), 32'(base + 1));

        // R9 continuous conversions
        bus_write(8'h18, 32'h40);
        base = start_cnt;
        repeat (3) exp_q.push_back(2);
        bus_write(8'h00, 32'h02);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        bus_write(8'h00, 32'h1F);
        bus_write(8'h18, 32'h00);
        idle(20);
        check("R9 repeat count", 32'(start_cnt), 32'(base + 3));
        check("R9 queue drained", 32'(exp_q.size()), 32'h0);

        // R10 R11 calibration with fail then pass
        bus_read(8'h0C, keep);
        fail_next = 1'b1;
        exp_q.push_back(CALTAG);
        bus_write(8'h18, 32'h80);
        check("R10 cal pulse", 32'(eng_cal), 32'h1);
        read_check("R10 bit pending", 8'h18, 32'h80);
        idle(8);
        read_check("R10 bit cleared", 8'h18, 32'h0);
        read_check("R10 completion flag", 8'h08, 32'h1);
        read_check("R11 fail latched", 8'h1C, 32'h2);
        bus_write(8'h1C, 32'h0);
        read_check("R11 write 0 kept", 8'h1C, 32'h2);
        bus_write(8'h1C, 32'h2);
        read_check("R11 w1c", 8'h1C, 32'h0);
        fail_next = 1'b0;
        exp_q.push_back(CALTAG);
        bus_write(8'h18, 32'h80);
        idle(8);
        read_check("R11 pass", 8'h1C, 32'h0);
        bus_read(8'h0C, keep);

        // R12 illegal addresses
        base = start_cnt;
        bus_write(8'h02, 32'h0000_0083);
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        read_check("R12 ctl0 intact", 8'h00, 32'h1F);
        read_check("R12 above range", 8'h34, 32'h0);
        read_check("R12 hole", 8'h2C, 32'h0);
        read_check("R12 misaligned", 8'h01, 32'h0);
        check("R12 no launch", 32'(start_cnt), 32'(base));

        // R13 storage and read-only registers
        bus_write(8'h20, 32'hA5A5_1234);
        bus_write(8'h24, 32'h0F0F_0F0F);
        bus_write(8'h28, 32'h1357_9BDF);
        bus_write(8'h30, 32'hDEAD_BEEF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'h25);
        read_check("R13 compare", 8'h20, 32'hA5A5_1234);
        read_check("R13 offset", 8'h24, 32'h0F0F_0F0F);
        read_check("R13 cal value", 8'h28, 32'h1357_9BDF);
        read_check("R13 pins", 8'h30, 32'hDEAD_BEEF);
        read_check("R13 ctl1", 8'h04, 32'h9F);
        read_check("R13 gctl low", 8'h18, 32'h25);
        bus_write(8'h08, 32'h1);
        bus_write(8'h0C, 32'h55);
        read_check("R13 status ro", 8'h08, 32'h0);
        read_check("R13 result ro", 8'h0C, keep);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule